// File: doc/BRIEF.md
# Grid Scan and Duty Timing Generator

This block drives the time multiplexing of a dot-matrix vacuum fluorescent display with 9 to 24 digit positions. It runs from the oscillator clock and splits time into digit slots of a fixed length. In each slot one grid line is selected. The block also presents that digit's index, so the character and symbol RAMs can be read for it. A segment-enable window opens at the start of each slot and stays open for a programmable number of clocks, and that number sets the brightness. The same window gates both the grid line and the segments, so every grid change falls inside a blank interval.

Three control values come in as plain levels:
- a 4-bit digit-count code,
- a 10-bit duty value,
- a 2-bit lighting mode.

The block samples all three only at the end of a slot. Software can therefore rewrite them at any time without causing a shortened pulse. The pattern lookup and the high-voltage output stages are outside the block. They take `digit_idx`, `seg_en` and `seg_all` from it.

Top module: `grid_scan_timing`

## Requirements
- R1: While `rst_n` is low, and in the first slot after it is released, every grid line is low, `seg_en` and `seg_all` are 0, and `digit_idx` is 0. The active duty resets to 0, so this first slot stays dark.
- R2: A digit slot is exactly 1024 clock cycles long. `digit_idx` changes only on the clock edge that ends a slot.
- R3: For a duty value D of 959 or less, the grid line and the window are active during the first D cycles of every slot and inactive for the rest of the slot.
- R4: A duty value of 960 (3C0h) or more acts as 960. Each slot therefore ends with at least 64 blank cycles.
- R5: With a duty value of 0, no grid line, `seg_en` or `seg_all` is ever asserted.
- R6: Digit-count code 0 enables 24 digits. A code k from 1 to 15 enables k+8 digits. `digit_idx` steps by one per slot, starting from 0, and returns to 0 after the last enabled digit.
- R7: At most one grid line is high at a time, and it is the bit given by `digit_idx` (bit 0 is the first grid). Grid lines beyond the enabled digit count never go high.
- R8: In normal mode (`lit_mode` 00), `seg_en` is high in exactly the cycles in which a grid line is high, and `seg_all` is 0.
- R9: A new duty, digit-count code or mode takes effect only at the next slot boundary. If `digit_idx` is at or above the new last digit at that boundary, it returns to 0.
- R10: Lighting mode is encoded as follows:
  - 01 blanks the segments: `seg_en` and `seg_all` are 0, while the grid lines keep scanning.
  - 10 or 11 lights all segments: `seg_en` and `seg_all` are both high throughout the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_code | input | 4 | Digit-count code (0 = 24 digits, k = k+8 digits) |
| duty | input | 10 | Window length per slot in clocks, clamped to 960 |
| lit_mode | input | 2 | 00 normal, 01 segments blank, 1x all segments lit |
| grid_o | output | 24 | One-hot grid enables, bit 0 = first digit |
| digit_idx | output | 5 | Index of the digit in the current slot |
| seg_en | output | 1 | Segment window: pattern data may be shown |
| seg_all | output | 1 | Force all segments of the current digit on |

## Verification
A slot counter that is off by even one cycle moves the window edge away from cycle D. It also moves the index step away from a multiple of 1024 cycles, so the error appears within the first lit slot after reset. A wrong digit counter or a wrong count decode shows up in two ways: the wrap from the last digit back to 0 comes one slot early or late, or a grid line beyond the count goes high. Either becomes visible once a full frame has elapsed. A configuration that is taken up mid-slot changes the window length within the same slot, so a check placed between the old and the new duty edge exposes it immediately.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;

  typedef enum logic [1:0] {
    LIT_NORMAL  = 2'b00,
    LIT_BLANK   = 2'b01,
    LIT_ALL     = 2'b10,
    LIT_ALL_ALT = 2'b11
  } lit_mode_e;

  // Segments may show data in this mode (pattern or forced)
  function automatic logic lit_shows(lit_mode_e m);
    return m != LIT_BLANK;
  endfunction

  // All segments are forced on in this mode
  function automatic logic lit_forces(lit_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/grid_scan_cfg.sv
module grid_scan_cfg
  import grid_scan_pkg::*;
#(
  parameter int SLOT_W     = 10,
  parameter int MIN_BLANK  = 64,
  parameter int DUTY_W     = 10,
  parameter int CODE_W     = 4,
  parameter int MAX_DIGITS = 24,
  parameter int DIGIT_BASE = 8,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [CODE_W-1:0] code_in,
  input  lit_mode_e         mode_in,
  output logic [SLOT_W-1:0] act_duty,
  output lit_mode_e         act_mode,
  output logic [IDX_W-1:0]  act_last,
  output logic [IDX_W-1:0]  last_next
);

  localparam int MAX_ON = (1 << SLOT_W) - MIN_BLANK;

  logic [SLOT_W-1:0] duty_clamped;

  always_comb begin
    if (32'(duty_in) >= MAX_ON) duty_clamped = SLOT_W'(MAX_ON);
    else                        duty_clamped = SLOT_W'(duty_in);
  end

  always_comb begin
    if (code_in == '0) last_next = IDX_W'(MAX_DIGITS - 1);
    else               last_next = IDX_W'(32'(code_in) + DIGIT_BASE - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_duty <= '0;
      act_mode <= LIT_NORMAL;
      act_last <= IDX_W'(MAX_DIGITS - 1);
    end else if (load) begin
      act_duty <= duty_clamped;
      act_mode <= mode_in;
      act_last <= last_next;
    end
  end

  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_duty) <= MAX_ON);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_duty) && $stable(act_mode) && $stable(act_last)));

endmodule

// File: rtl/grid_slot_timer.sv
module grid_slot_timer #(
  parameter int SLOT_W    = 10,
  parameter int MIN_BLANK = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] act_duty,
  output logic              step,
  output logic              win
);

  localparam int MAX_ON = (1 << SLOT_W) - MIN_BLANK;

  logic [SLOT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign step = &cnt;
  assign win  = cnt < act_duty;

  p_blank_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) >= MAX_ON) |-> !win);

  p_step_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

endmodule

// File: rtl/grid_digit_seq.sv
module grid_digit_seq #(
  parameter int MAX_DIGITS = 24,
  parameter int IDX_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  win,
  input  logic [IDX_W-1:0]      last_next,
  input  logic [IDX_W-1:0]      act_last,
  output logic [IDX_W-1:0]      dig,
  output logic [MAX_DIGITS-1:0] grid_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dig <= '0;
    else if (step)
      dig <= (dig >= last_next) ? '0 : dig + 1'b1;
  end

  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_line
    assign grid_o[g] = win && (dig == IDX_W'(g));
  end

  p_idx_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(dig));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dig <= act_last);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_o));

  p_grid_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_o != '0) |-> grid_o[dig]);

endmodule

// File: rtl/grid_scan_timing.sv
module grid_scan_timing
  import grid_scan_pkg::*;
#(
  parameter int SLOT_W     = 10,
  parameter int MIN_BLANK  = 64,
  parameter int DUTY_W     = 10,
  parameter int CODE_W     = 4,
  parameter int MAX_DIGITS = 24,
  parameter int DIGIT_BASE = 8,
  parameter int IDX_W      = $clog2(MAX_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     digit_code,
  input  logic [DUTY_W-1:0]     duty,
  input  logic [1:0]            lit_mode,
  output logic [MAX_DIGITS-1:0] grid_o,
  output logic [IDX_W-1:0]      digit_idx,
  output logic                  seg_en,
  output logic                  seg_all
);

  logic              step;
  logic              win;
  logic [SLOT_W-1:0] act_duty;
  lit_mode_e         act_mode;
  logic [IDX_W-1:0]  act_last;
  logic [IDX_W-1:0]  last_next;

  grid_scan_cfg #(
    .SLOT_W(SLOT_W), .MIN_BLANK(MIN_BLANK), .DUTY_W(DUTY_W),
    .CODE_W(CODE_W), .MAX_DIGITS(MAX_DIGITS), .DIGIT_BASE(DIGIT_BASE),
    .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(step),
    .duty_in(duty), .code_in(digit_code), .mode_in(lit_mode_e'(lit_mode)),
    .act_duty(act_duty), .act_mode(act_mode),
    .act_last(act_last), .last_next(last_next)
  );

  grid_slot_timer #(.SLOT_W(SLOT_W), .MIN_BLANK(MIN_BLANK)) u_timer (
    .clk(clk), .rst_n(rst_n), .act_duty(act_duty),
    .step(step), .win(win)
  );

  grid_digit_seq #(.MAX_DIGITS(MAX_DIGITS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .win(win),
    .last_next(last_next), .act_last(act_last),
    .dig(digit_idx), .grid_o(grid_o)
  );

  assign seg_en  = win && lit_shows(act_mode);
  assign seg_all = win && lit_forces(act_mode);

  p_seg_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == LIT_NORMAL) |-> (seg_en == (grid_o != '0)) && !seg_all);

  p_blank_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == LIT_BLANK) |-> (!seg_en && !seg_all));

endmodule

// File: tb/grid_scan_timing_bench.sv
module grid_scan_timing_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 1024;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  digit_code = '0;
  logic [9:0]  duty = '0;
  logic [1:0]  lit_mode = '0;
  logic [23:0] grid_o;
  logic [4:0]  digit_idx;
  logic        seg_en;
  logic        seg_all;

  grid_scan_timing u_grid_scan_timing (
    .clk(clk), .rst_n(rst_n), .digit_code(digit_code), .duty(duty),
    .lit_mode(lit_mode), .grid_o(grid_o), .digit_idx(digit_idx),
    .seg_en(seg_en), .seg_all(seg_all)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;
  int    k;
  int    adv_k;
  int    exp_dig;
  int    mm;
  string first_mm;
  bit    hi_seen;
  int    beyond_hits;

  task automatic check(input bit ok, input string req, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic close_check(input string req);
    check(mm == 0, req,
          $sformatf("%0d mismatching cycles, first (actual/expected) %s", mm, first_mm));
    mm = 0;
    first_mm = "";
  endtask

  task automatic start(input int code, input int d, input int mode);
    @(negedge clk);
    rst_n = 1'b0;
    digit_code = 4'(code);
    duty = 10'(d);
    lit_mode = 2'(mode);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    adv_k = 0;
    exp_dig = 0;
    mm = 0;
    first_mm = "";
    hi_seen = 0;
    beyond_hits = 0;
  endtask

  // n, d, mode: digit count, effective duty and mode of the slots covered
  task automatic run_cycles(input int count, input int n, input int d, input int mode);
    for (int i = 0; i < count; i++) begin
      logic [23:0] eg;
      bit on, ee, ea;
      if (k > 0 && (k % SLOT) == 0 && adv_k != k) begin
        exp_dig = (exp_dig >= n - 1) ? 0 : exp_dig + 1;
        adv_k = k;
      end
      on = (k % SLOT) < d;
      eg = on ? (24'(1) << exp_dig) : 24'(0);
      ee = on && (mode != 1);
      ea = on && (mode >= 2);
      if (grid_o[23]) hi_seen = 1;
      for (int g = n; g < 24; g++) if (grid_o[g]) beyond_hits++;
      if (grid_o !== eg || digit_idx !== 5'(exp_dig) || seg_en !== ee || seg_all !== ea) begin
        if (mm == 0)
          first_mm = $sformatf("k=%0d grid=%h/%h idx=%0d/%0d en=%b/%b all=%b/%b",
                               k, grid_o, eg, digit_idx, exp_dig, seg_en, ee, seg_all, ea);
        mm++;
      end
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    duty = 10'h3FF;
    lit_mode = 2'b10;
    repeat (2) @(negedge clk);
    check(grid_o === '0, "R1", $sformatf("grid %h/0", grid_o));
    check(digit_idx === '0, "R1", $sformatf("idx %0d/0", digit_idx));
    check(seg_en === 1'b0, "R1", $sformatf("seg_en %b/0", seg_en));
    check(seg_all === 1'b0, "R1", $sformatf("seg_all %b/0", seg_all));
    start(0, 1023, 2);
    run_cycles(SLOT, 24, 0, 2);
    close_check("R1 dark first slot");
  endtask

  task automatic t_full24_clamp;
    start(0, 10'h3FF, 0);
    run_cycles(SLOT, 24, 0, 0);
    run_cycles(25 * SLOT, 24, 960, 0);
    close_check("R2 R4 R6 R7 R8 24 digits, clamped duty");
    check(hi_seen, "R6", "grid 24 never lit (actual 0, expected 1)");
  endtask

  task automatic t_nine_low_duty;
    start(1, 5, 0);
    run_cycles(SLOT, 9, 0, 0);
    run_cycles(10 * SLOT, 9, 5, 0);
    close_check("R3 R6 R8 nine digits, duty 5");
    check(beyond_hits == 0, "R7", $sformatf("lines past count lit %0d/0 cycles", beyond_hits));
  endtask

  task automatic t_ten_959;
    start(2, 10'h3BF, 0);
    run_cycles(SLOT, 10, 0, 0);
    run_cycles(11 * SLOT, 10, 959, 0);
    close_check("R3 R4 R6 ten digits, duty 959");
  endtask

  task automatic t_zero_duty;
    start(0, 0, 2);
    run_cycles(3 * SLOT, 24, 0, 2);
    close_check("R5 duty zero");
  endtask

  task automatic t_duty_change_mid;
    start(0, 100, 0);
    run_cycles(SLOT, 24, 0, 0);
    run_cycles(300, 24, 100, 0);
    duty = 10'd700;
    digit_code = 4'd1;
    run_cycles(SLOT - 300, 24, 100, 0);
    run_cycles(2 * SLOT, 9, 700, 0);
    close_check("R9 duty change waits for boundary");
  endtask

  task automatic t_count_shrink;
    start(0, 50, 0);
    run_cycles(SLOT, 24, 0, 0);
    run_cycles(12 * SLOT + 10, 24, 50, 0);
    digit_code = 4'd1;
    run_cycles(SLOT - 10, 24, 50, 0);
    run_cycles(10 * SLOT, 9, 50, 0);
    close_check("R9 R6 count shrink wraps index");
  endtask

  task automatic t_modes;
    start(1, 400, 1);
    run_cycles(SLOT, 9, 0, 1);
    run_cycles(3 * SLOT, 9, 400, 1);
    close_check("R10 blank mode");
    lit_mode = 2'b10;
    run_cycles(SLOT, 9, 400, 1);
    lit_mode = 2'b11;
    run_cycles(SLOT, 9, 400, 2);
    run_cycles(SLOT, 9, 400, 3);
    close_check("R10 R9 all-on modes");
  endtask

  initial begin
    t_reset();
    t_full24_clamp();
    t_nine_low_duty();
    t_ten_959();
    t_zero_duty();
    t_duty_change_mid();
    t_count_shrink();
    t_modes();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end (actual hung, expected done)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule